// File: doc/BRIEF.md
# Strobed FIFO with Retransmit

This block is a single-port-pair first-in/first-out buffer of 9-bit words whose depth is a parameter (256, 512 or 1024 locations). A producer pulses an active-low write strobe and a consumer pulses an active-low read strobe. Both strobes are sampled on the system clock, and each operation is split into a start (strobe falling) and a completion (strobe rising). Words come out in the order they went in. No addresses are supplied from outside.

Three active-low flags report the fill level: empty, full, and more-than-half-full. A read that starts while the buffer is empty is dropped, and so is a write that starts while it is full. A low level on the retransmit input rewinds the read side to the first location and leaves the write side alone, so the stored sequence can be played out again from the start.

Top module: `strobed_fifo`

## Requirements
- R1: While rst_n is low, and after it is released, both pointers sit at location zero and the outputs read empty_n=0, full_n=1, half_n=1, dout_vld=0.
- R2: A write starts at the first clock edge that sees wr_n low after it was high, provided full_n is 1 at that edge. din is stored at that edge. At the edge that sees wr_n high again, the write pointer and occupancy advance, and the flags reflect this right after that edge.
- R3: A read starts at the first clock edge that sees rd_n low, provided empty_n is 1 at that edge. From then until rd_n rises, dout carries the oldest unread word. At the edge that sees rd_n high again, the read pointer advances and occupancy drops.
- R4: While rt_n is low (with both strobes high), the read pointer returns to location zero, the write pointer is unchanged, and occupancy becomes the number of words written since reset. The next reads replay from the first word.
- R5: dout_vld is 1 only while rd_n is low during an accepted read. It is 0 whenever rd_n is high or the read was refused because the buffer was empty.
- R6: empty_n is 0 exactly when occupancy is zero. A read started while empty raises no dout_vld and moves no pointer.
- R7: full_n is 0 exactly when occupancy equals the depth. A write started while full stores nothing and moves no pointer.
- R8: half_n is 0 exactly when occupancy exceeds half the depth. It asserts on completion of the write that reaches half+1 and releases on completion of the read that brings occupancy back to half.
- R9: A write completion and a read completion in the same clock leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit request |
| din | input | 9 | Word to be stored |
| dout | output | 9 | Word at the read position |
| dout_vld | output | 1 | dout holds an accepted read word |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |
| half_n | output | 1 | Active-low more-than-half-full flag |

## Verification
The assertions assume the legal use of the pins: rt_n is only taken low while both strobes are high and no operation is in progress, and retransmit is only used while at most one depth of words has been written since reset. Under these assumptions, a read in progress always has a word behind it and the write pointer cannot move during a rewind. The directed tasks keep to this: they drive each strobe low and high again on separate falling clock edges, pulse rt_n only between complete operations, and reset before each retransmit scenario.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sfifo_strobe.sv
// Edge finder for one active-low strobe sampled on clk.
module sfifo_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = strobe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~strobe_n;
    assign rise = ~prev_q & strobe_n;
endmodule

// File: rtl/sfifo_ram.sv
// Storage array: one synchronous write port, one combinational read port.
module sfifo_ram
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/strobed_fifo.sv
module strobed_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic        rt_n,
    input  logic [8:0]  din,
    output logic [8:0]  dout,
    output logic        dout_vld,
    output logic        empty_n,
    output logic        full_n,
    output logic        half_n
);
    localparam int          AW     = $clog2(DEPTH);
    localparam int          CW     = AW + 1;
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    typedef struct packed {
        logic [CW-1:0] wptr;
        logic [CW-1:0] rptr;
        logic [CW-1:0] count;
        logic          wr_act;
        logic          rd_act;
    } state_t;

    state_t s_d, s_q;
    logic   wr_fall, wr_rise, rd_fall, rd_rise;
    logic   ram_we, inc, dec;
    word_t  rdata;

    sfifo_strobe u_wr_edge (.clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .fall(wr_fall), .rise(wr_rise));
    sfifo_strobe u_rd_edge (.clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .fall(rd_fall), .rise(rd_rise));

    sfifo_ram #(.DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (s_q.wptr[AW-1:0]),
        .wdata (din),
        .raddr (s_q.rptr[AW-1:0]),
        .rdata (rdata)
    );

    always_comb begin
        s_d    = s_q;
        ram_we = 1'b0;
        inc    = wr_rise & s_q.wr_act;
        dec    = rd_rise & s_q.rd_act;
        if (!rt_n) begin
            s_d.rptr   = '0;
            s_d.count  = s_q.wptr;
            s_d.rd_act = 1'b0;
            s_d.wr_act = 1'b0;
        end else begin
            if (wr_fall && s_q.count != FULL_C) begin
                s_d.wr_act = 1'b1;
                ram_we     = 1'b1;
            end
            if (inc) begin
                s_d.wptr   = s_q.wptr + 1'b1;
                s_d.wr_act = 1'b0;
            end
            if (rd_fall && s_q.count != '0) s_d.rd_act = 1'b1;
            if (dec) begin
                s_d.rptr   = s_q.rptr + 1'b1;
                s_d.rd_act = 1'b0;
            end
            s_d.count = s_q.count + CW'(inc) - CW'(dec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout     = rdata;
    assign dout_vld = s_q.rd_act & ~rd_n;
    assign empty_n  = (s_q.count != '0);
    assign full_n   = (s_q.count != FULL_C);
    assign half_n   = ~(s_q.count > HALF_C);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= FULL_C);                                         // R7
    AST_NO_RD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_fall && rt_n) |=> !s_q.rd_act);               // R6
    AST_NO_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_fall && rt_n) |=> !s_q.wr_act);                // R7
    AST_RT_KEEPS_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_n) |=> $stable(s_q.wptr));                               // R4
    AST_VLD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> empty_n);                                        // R5
    AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !half_n |-> empty_n);                                         // R8
endmodule

// File: tb/strobed_fifo_test.sv
`timescale 1ns/1ps
module strobed_fifo_test;
    localparam int DEPTH = 256;
    localparam int HALF  = DEPTH / 2;

    logic clk = 1'b0;
    logic rst_n, wr_n, rd_n, rt_n;
    logic [8:0] din, dout;
    logic dout_vld, empty_n, full_n, half_n;
    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [8:0] got;
    logic got_vld;

    always #4 clk = ~clk;

    strobed_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_vld(dout_vld),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; din = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge clk); wr_n = 1'b0; din = d;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd();
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); got = dout; got_vld = dout_vld; rd_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 7 + 3) & 9'h1FF);
    endfunction

    task automatic t_reset();
        do_reset();
        check("R1 empty_n", empty_n, 0);
        check("R1 full_n", full_n, 1);
        check("R1 half_n", half_n, 1);
        check("R1 dout_vld", dout_vld, 0);
    endtask

    task automatic t_basic();
        do_reset();
        wr(9'h0A1);
        check("R2 empty released", empty_n, 1);
        wr(9'h1B2); wr(9'h0C3);
        check("R5 vld low idle", dout_vld, 0);
        rd(); check("R3 word0", got, 9'h0A1); check("R5 vld", got_vld, 1);
        rd(); check("R3 word1", got, 9'h1B2);
        rd(); check("R3 word2", got, 9'h0C3);
        check("R6 empty after drain", empty_n, 0);
    endtask

    task automatic t_empty_read();
        do_reset();
        rd(); check("R6 refused read vld", got_vld, 0);
        check("R6 still empty", empty_n, 0);
        wr(9'h155);
        rd(); check("R6 pointer unmoved", got, 9'h155);
        check("R6 empty again", empty_n, 0);
    endtask

    task automatic t_retransmit();
        do_reset();
        for (int i = 0; i < 5; i++) wr(pat(i));
        rd(); rd();
        @(negedge clk); rt_n = 1'b0;
        @(negedge clk); rt_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            rd(); check("R4 replay", got, pat(i));
        end
        check("R4 empty after replay", empty_n, 0);
        wr(9'h0EE);
        rd(); check("R4 write pointer kept", got, 9'h0EE);
    endtask

    task automatic t_half_full();
        do_reset();
        for (int i = 0; i < HALF; i++) wr(pat(i));
        check("R8 half at exactly half", half_n, 1);
        wr(pat(HALF));
        check("R8 half asserted", half_n, 0);
        for (int i = HALF + 1; i < DEPTH - 1; i++) wr(pat(i));
        check("R7 not full at depth-1", full_n, 1);
        wr(pat(DEPTH - 1));
        check("R7 full", full_n, 0);
        wr(9'h1FF);
        check("R7 still full", full_n, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            if (got !== pat(i)) check("R7 order after full", got, pat(i));
            if (i == 0) check("R7 full released", full_n, 1);
            if (i == HALF - 2) check("R8 half held", half_n, 0);
            if (i == HALF - 1) check("R8 half released", half_n, 1);
        end
        check("R7 refused word not stored", empty_n, 0);
    endtask

    task automatic t_simul();
        do_reset();
        for (int i = 0; i <= HALF; i++) wr(pat(i));
        check("R9 half before", half_n, 0);
        @(negedge clk); wr_n = 1'b0; rd_n = 1'b0; din = 9'h0AA;
        @(negedge clk); got = dout; wr_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        check("R9 read data", got, pat(0));
        check("R9 count unchanged", half_n, 0);
        rd();
        check("R9 one read to half", half_n, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_empty_read();
        t_retransmit();
        t_half_full();
        t_simul();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule